// File: doc/BRIEF.md
# Four-State Hard-Decision Viterbi Decoder

This block recovers the data bits of a frame that was protected by a rate one-half convolutional code with constraint length three, where the first coded bit of each symbol uses the taps 1+D+D² and the second uses 1+D². Its input is one received two-bit hard-decision symbol per accepted cycle. The frame length is fixed by a parameter and includes two trailing zero-input symbols. These force the transmitter's shift register back to the all-zero state.

For every symbol the decoder forms Hamming-distance branch metrics and updates four path metrics with add-compare-select. It writes one survivor decision per state into a small survivor store. After the last symbol it walks the stored decisions backward from the zero state. The recovered data bits go into an output buffer, and the decoder then emits them oldest first as a short valid/last burst. The tail bits are not emitted. While it traces back and emits, the block reports busy and ignores its input.

Top module: `viterbi4_dec`

## Requirements
- R1: After reset, `busy`, `dec_valid` and `dec_last` are 0 and the block accepts a symbol whenever `sym_valid` is 1.
- R2: Each symbol is `sym_in = {c0, c1}`, with bit 1 holding c0 = u^D^D² and bit 0 holding c1 = u^D². D is the previous input and D² the one before it, and the encoder starts from zero. A frame of DATA_BITS data symbols plus two zero-input tail symbols, received without error, decodes to exactly the transmitted data bits.
- R3: Any single corrupted channel bit anywhere in the frame is corrected. Example: the received bit pairs 11 01 10 10 01 01 10 11 00 decode to 1,1,1,1,0,1,0.
- R4: For any received sequence, the output equals maximum-likelihood decoding under these rules:
  - the branch metric is the Hamming distance (0, 1 or 2);
  - state 0 starts at metric 0 and the other states start at PM_UNREACH;
  - additions saturate at 2^PM_W-1;
  - on equal candidates, the predecessor whose oldest register bit is 0 wins;
  - traceback starts from state 0.
- R5: Each frame gives exactly DATA_BITS pulses of `dec_valid` on consecutive cycles, oldest bit first. `dec_last` is asserted only with the final pulse.
- R6: `busy` rises the cycle after the edge that accepts the last symbol of a frame. The first `dec_valid` follows FRAME_SYMS+1 cycles after that edge. `busy` falls in the cycle that carries `dec_last`.
- R7: Symbols offered while `busy` is 1 are ignored. They change neither the current output nor the next frame.
- R8: Frames may follow one another with no gap. Path metrics return to their initial values at every frame boundary, and `sym_valid` may drop for any number of cycles within a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sym_valid | input | 1 | Received symbol present |
| sym_in | input | 2 | Hard-decision symbol {c0, c1} |
| busy | output | 1 | Traceback or emission in progress; input ignored |
| dec_valid | output | 1 | Decoded bit present |
| dec_bit | output | 1 | Decoded data bit |
| dec_last | output | 1 | Final decoded bit of the frame |

## Verification
A wrong path metric or survivor decision does not show at the ports while the frame streams in. It appears only FRAME_SYMS+1 cycles after the last symbol, as a wrong bit in the output burst. Noisy received frames are therefore compared bit by bit with a maximum-likelihood model that uses the same tie and saturation rules. A sequencing fault, such as a miscounted frame or a premature busy release, shows at once as a shifted `dec_valid`/`dec_last` window or a shifted `busy` window. A metric that is not reset between frames corrupts the frame after it.

// File: rtl/vit_pkg.sv
package vit_pkg;

  localparam int NSTATE = 4;
  localparam int TAIL_SYMS = 2;

  typedef enum logic [1:0] {PH_FILL, PH_TRACE, PH_EMIT} phase_t;

  // Coded pair leaving state {D, D2} when input u is shifted in: {c0, c1}
  function automatic logic [1:0] branch_sym(input logic [1:0] from_st, input logic u);
    return {u ^ from_st[1] ^ from_st[0], u ^ from_st[0]};
  endfunction

endpackage

// File: rtl/vit_bmu.sv
module vit_bmu
  import vit_pkg::*;
(
  input  logic                         [1:0] sym,
  output logic [NSTATE-1:0][1:0]       [1:0] bm
);

  // Destination state n = {u, D}; predecessor x-th branch = {D, x}
  for (genvar n = 0; n < NSTATE; n++) begin : g_dst
    for (genvar x = 0; x < 2; x++) begin : g_br
      localparam logic [1:0] PRED = {1'(n % 2), 1'(x)};
      localparam logic       UIN  = 1'(n / 2);
      localparam logic [1:0] EXP  = branch_sym(PRED, UIN);
      logic [1:0] diff;
      assign diff        = sym ^ EXP;
      assign bm[n][x]    = {diff[1] & diff[0], diff[1] ^ diff[0]};
    end
  end

endmodule

// File: rtl/vit_acs.sv
module vit_acs
  import vit_pkg::*;
#(
  parameter int PM_W       = 5,
  parameter int PM_UNREACH = 15
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          step_en,
  input  logic                          restart,
  input  logic [NSTATE-1:0][1:0][1:0]   bm,
  output logic [NSTATE-1:0]             dec
);

  localparam logic [PM_W-1:0] INIT_HI = PM_W'(PM_UNREACH);

  logic [PM_W-1:0] pm_q [NSTATE];
  logic [PM_W-1:0] pm_d [NSTATE];

  function automatic logic [PM_W-1:0] sat_add(input logic [PM_W-1:0] a, input logic [1:0] b);
    logic [PM_W:0] s;
    s = {1'b0, a} + (PM_W+1)'(b);
    return s[PM_W] ? '1 : s[PM_W-1:0];
  endfunction

  for (genvar n = 0; n < NSTATE; n++) begin : g_acs
    localparam int P0 = (n % 2) * 2;
    localparam int P1 = (n % 2) * 2 + 1;
    logic [PM_W-1:0] cand0, cand1;
    assign cand0 = sat_add(pm_q[P0], bm[n][0]);
    assign cand1 = sat_add(pm_q[P1], bm[n][1]);
    // strict compare: a tie keeps the lower-numbered predecessor
    assign dec[n]  = (cand1 < cand0);
    assign pm_d[n] = dec[n] ? cand1 : cand0;

    always_ff @(posedge clk) begin
      if (rst || restart) begin
        pm_q[n] <= (n == 0) ? '0 : INIT_HI;
      end else if (step_en) begin
        pm_q[n] <= pm_d[n];
      end
    end
  end

endmodule

// File: rtl/vit_trace.sv
module vit_trace
  import vit_pkg::*;
#(
  parameter int DATA_BITS  = 7,
  parameter int FRAME_SYMS = DATA_BITS + TAIL_SYMS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sym_valid,
  input  logic [NSTATE-1:0] dec,
  output logic              sym_fire,
  output logic              frame_end,
  output logic              busy,
  output logic              dec_valid,
  output logic              dec_bit,
  output logic              dec_last
);

  localparam int AW = (FRAME_SYMS > 1) ? $clog2(FRAME_SYMS) : 1;
  localparam int EW = $clog2(DATA_BITS + 1);
  localparam logic [AW-1:0] LAST_STEP = AW'(FRAME_SYMS - 1);
  localparam logic [AW-1:0] DATA_LIM  = AW'(DATA_BITS);
  localparam logic [EW-1:0] LAST_OUT  = EW'(DATA_BITS - 1);

  phase_t              phase_q;
  logic [AW-1:0]       wr_ptr_q;
  logic [AW-1:0]       tb_ptr_q;
  logic [1:0]          tb_st_q;
  logic [EW-1:0]       emit_cnt_q;
  logic [DATA_BITS-1:0] bits_q;
  logic [NSTATE-1:0]   surv_mem [FRAME_SYMS];
  logic [NSTATE-1:0]   rd_word;

  assign busy      = (phase_q != PH_FILL);
  assign sym_fire  = sym_valid && !busy;
  assign frame_end = sym_fire && (wr_ptr_q == LAST_STEP);

  // survivor store: one word per trellis step, no reset
  always_ff @(posedge clk) begin
    if (sym_fire) surv_mem[wr_ptr_q] <= dec;
  end
  assign rd_word = surv_mem[tb_ptr_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_FILL;
      wr_ptr_q   <= '0;
      tb_ptr_q   <= '0;
      tb_st_q    <= '0;
      emit_cnt_q <= '0;
      bits_q     <= '0;
      dec_valid  <= 1'b0;
      dec_bit    <= 1'b0;
      dec_last   <= 1'b0;
    end else begin
      dec_valid <= 1'b0;
      dec_last  <= 1'b0;
      unique case (phase_q)
        PH_FILL: begin
          if (sym_fire) begin
            if (wr_ptr_q == LAST_STEP) begin
              wr_ptr_q <= '0;
              tb_ptr_q <= LAST_STEP;
              tb_st_q  <= '0;
              phase_q  <= PH_TRACE;
            end else begin
              wr_ptr_q <= wr_ptr_q + 1'b1;
            end
          end
        end
        PH_TRACE: begin
          // input bit of the step that entered tb_st is its newest register bit
          if (tb_ptr_q < DATA_LIM) bits_q <= {bits_q[DATA_BITS-2:0], tb_st_q[1]};
          tb_st_q <= {tb_st_q[0], rd_word[tb_st_q]};
          if (tb_ptr_q == '0) begin
            emit_cnt_q <= '0;
            phase_q    <= PH_EMIT;
          end else begin
            tb_ptr_q <= tb_ptr_q - 1'b1;
          end
        end
        PH_EMIT: begin
          dec_valid <= 1'b1;
          dec_bit   <= bits_q[0];
          bits_q    <= {1'b0, bits_q[DATA_BITS-1:1]};
          if (emit_cnt_q == LAST_OUT) begin
            dec_last <= 1'b1;
            phase_q  <= PH_FILL;
          end else begin
            emit_cnt_q <= emit_cnt_q + 1'b1;
          end
        end
        default: phase_q <= PH_FILL;
      endcase
    end
  end

endmodule

// File: rtl/viterbi4_dec.sv
module viterbi4_dec
  import vit_pkg::*;
#(
  parameter int DATA_BITS  = 7,
  parameter int FRAME_SYMS = DATA_BITS + TAIL_SYMS,
  parameter int PM_W       = 5,
  parameter int PM_UNREACH = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sym_valid,
  input  logic [1:0] sym_in,
  output logic       busy,
  output logic       dec_valid,
  output logic       dec_bit,
  output logic       dec_last
);

  logic [NSTATE-1:0][1:0][1:0] bm;
  logic [NSTATE-1:0]           dec;
  logic                        sym_fire;
  logic                        frame_end;

  vit_bmu u_bmu (
    .sym (sym_in),
    .bm  (bm)
  );

  vit_acs #(
    .PM_W       (PM_W),
    .PM_UNREACH (PM_UNREACH)
  ) u_acs (
    .clk     (clk),
    .rst     (rst),
    .step_en (sym_fire),
    .restart (frame_end),
    .bm      (bm),
    .dec     (dec)
  );

  vit_trace #(
    .DATA_BITS  (DATA_BITS),
    .FRAME_SYMS (FRAME_SYMS)
  ) u_trace (
    .clk       (clk),
    .rst       (rst),
    .sym_valid (sym_valid),
    .dec       (dec),
    .sym_fire  (sym_fire),
    .frame_end (frame_end),
    .busy      (busy),
    .dec_valid (dec_valid),
    .dec_bit   (dec_bit),
    .dec_last  (dec_last)
  );

endmodule

// File: rtl/viterbi4_dec_chk.sv
module viterbi4_dec_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic dec_valid,
  input logic dec_last
);

  a_r5_last_has_valid: assert property (@(posedge clk) disable iff (rst)
    dec_last |-> dec_valid);

  a_r5_burst_contiguous: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !dec_last) |=> dec_valid);

  a_r5_burst_ends: assert property (@(posedge clk) disable iff (rst)
    dec_last |=> !dec_valid);

  a_r6_busy_drops_on_last: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> dec_last);

  a_r6_valid_inside_busy: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !dec_last) |-> busy);

endmodule

bind viterbi4_dec viterbi4_dec_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .dec_valid (dec_valid),
  .dec_last  (dec_last)
);

// File: tb/viterbi4_dec_test.sv
module viterbi4_dec_test;

  localparam int D = 7;
  localparam int F = D + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sym_valid = 1'b0;
  logic [1:0] sym_in = 2'b00;
  logic busy, dec_valid, dec_bit, dec_last;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  logic [1:0] rx [F];

  always #5 clk = ~clk;

  viterbi4_dec uut (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_in(sym_in),
    .busy(busy), .dec_valid(dec_valid), .dec_bit(dec_bit), .dec_last(dec_last)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // encoder from R2: symbol {c0,c1}, state {D,D2}
  function automatic void encode(input logic [D-1:0] data);
    logic [1:0] st = 2'b00;
    for (int t = 0; t < F; t++) begin
      logic u = (t < D) ? data[t] : 1'b0;
      rx[t] = {u ^ st[1] ^ st[0], u ^ st[0]};
      st = {u, st[1]};
    end
  endfunction

  function automatic logic [4:0] sadd(input logic [4:0] a, input int b);
    int s = int'(a) + b;
    return (s > 31) ? 5'd31 : 5'(s);
  endfunction

  // maximum-likelihood reference per R4
  function automatic logic [D-1:0] ref_decode();
    logic [4:0] pm [4];
    logic [4:0] np [4];
    logic [3:0] surv [F];
    logic [1:0] s;
    logic [D-1:0] r = '0;
    pm = '{5'd0, 5'd15, 5'd15, 5'd15};
    for (int t = 0; t < F; t++) begin
      for (int n = 0; n < 4; n++) begin
        logic [4:0] c [2];
        for (int x = 0; x < 2; x++) begin
          logic [1:0] p = {1'(n % 2), 1'(x)};
          logic u = 1'(n / 2);
          logic [1:0] e = {u ^ p[1] ^ p[0], u ^ p[0]};
          logic [1:0] df = e ^ rx[t];
          c[x] = sadd(pm[p], int'(df[0]) + int'(df[1]));
        end
        surv[t][n] = (c[1] < c[0]);
        np[n] = (c[1] < c[0]) ? c[1] : c[0];
      end
      pm = np;
    end
    s = 2'b00;
    for (int t = F - 1; t >= 0; t--) begin
      if (t < D) r[t] = s[1];
      s = {s[0], surv[t][s]};
    end
    return r;
  endfunction

  // drive rx[], observe burst; checks data and R5/R6 timing, noise exercises R7
  task automatic run_frame(input logic [D-1:0] exp, input string tag, input bit gaps, input bit noise);
    int i = 0;
    logic [D-1:0] got = '0;
    int nout = 0;
    bit tim_ok = 1'b1;
    while (i < F) begin
      @(negedge clk);
      if (gaps && ($urandom % 3 == 0)) begin
        sym_valid = 1'b0; sym_in = 2'($urandom);
      end else begin
        sym_valid = 1'b1; sym_in = rx[i]; i++;
      end
    end
    for (int k = 1; k <= F + D + 1; k++) begin
      @(negedge clk);
      if (busy !== (k <= F + D)) tim_ok = 1'b0;
      if (dec_valid !== (k >= F + 2)) tim_ok = 1'b0;
      if (dec_last !== (k == F + D + 1)) tim_ok = 1'b0;
      if (dec_valid === 1'b1 && nout < D) begin got[nout] = dec_bit; nout++; end
      if (noise && k <= F + D) begin
        sym_valid = 1'b1; sym_in = 2'($urandom);
      end else begin
        sym_valid = 1'b0;
      end
    end
    check(tim_ok, "R5/R6 burst and busy window", 32'(nout), 32'(D));
    check(got == exp, tag, 32'(got), 32'(exp));
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [D-1:0] data;
    void'($urandom(32'h1d0c5eed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(busy == 1'b0 && dec_valid == 1'b0 && dec_last == 1'b0, "R1 reset outputs",
          {29'd0, busy, dec_valid, dec_last}, 32'd0);

    // R3: directed example with one flipped bit in the sixth symbol
    rx = '{2'b11, 2'b01, 2'b10, 2'b10, 2'b01, 2'b01, 2'b10, 2'b11, 2'b00};
    run_frame(7'b0101111, "R3 directed single-error frame", 1'b0, 1'b0);

    // R2: error-free directed patterns
    encode(7'b0101111); run_frame(7'b0101111, "R2 clean directed frame", 1'b0, 1'b0);
    encode('0);         run_frame('0,         "R2 all-zero data",         1'b0, 1'b0);
    encode('1);         run_frame('1,         "R2 all-one data",          1'b0, 1'b0);

    // R2/R8: random clean frames, back to back, with input gaps
    for (int f = 0; f < 10; f++) begin
      data = D'($urandom);
      encode(data);
      run_frame(data, "R2/R8 random clean frame with gaps", 1'b1, 1'b0);
    end

    // R3/R7: every single-bit error position, with noise offered while busy
    for (int p = 0; p < 2 * F; p++) begin
      data = D'($urandom);
      encode(data);
      rx[p / 2][p % 2] = ~rx[p / 2][p % 2];
      run_frame(data, "R3/R7 single bit error, busy noise ignored", 1'b0, 1'b1);
    end

    // R4: arbitrary received sequences against the ML reference
    for (int f = 0; f < 30; f++) begin
      for (int t = 0; t < F; t++) rx[t] = 2'($urandom);
      run_frame(ref_decode(), "R4 noisy frame vs reference", 1'b0, (f % 2) == 1);
    end
    // R4: tie-heavy directed patterns
    for (int t = 0; t < F; t++) rx[t] = 2'b11;
    run_frame(ref_decode(), "R4 all-11 ties", 1'b0, 1'b0);
    for (int t = 0; t < F; t++) rx[t] = 2'(t % 2 + 1);
    run_frame(ref_decode(), "R4 alternating 01/10 ties", 1'b0, 1'b0);

    // R8: metrics restart after a noisy frame
    encode(7'b1010011);
    run_frame(7'b1010011, "R8 clean frame after noisy frames", 1'b0, 1'b0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule